// File: doc/BRIEF.md
# Serial FIFO Interrupt Status Unit

This block watches the transmit and receive FIFOs of a synchronous serial port and condenses what it sees into a twelve-bit status word and one interrupt line. Six of the status bits are live: they follow FIFO fill levels against programmable thresholds, and they follow two control-register handshake indications. The other six are sticky error flags. These flags latch on protocol faults:

- a host push into a full transmit FIFO;
- a host pop from an empty receive FIFO;
- a serial slot or word that meets an empty or full FIFO;
- a frame sync that arrives too early in slave mode;
- a slot number given to both data and control.

The host clears an error flag by writing a one to its bit. A per-bit enable mask selects which status bits can raise the interrupt. The interrupt output is registered.

The serial shifter and the FIFO storage are outside this block. The block only observes the levels and strobes they produce. A bit-tick strobe marks each serial bit period, so the block can count bits between frame syncs.

Top module: `sfifo_irq_status`

## Requirements
- R1: Status bit 0 (transmit request) is 1 exactly while `TX_DEPTH - tx_level` is greater than `tx_thresh`. It follows the inputs combinationally.
- R2: Status bit 1 (receive request) is 1 exactly while `rx_level` is greater than or equal to `rx_thresh`.
- R3: Status bit 2 is 1 exactly while `tx_level` is 0. Status bit 3 is 1 exactly while `rx_level` equals `RX_DEPTH`.
- R4: Status bit 4 mirrors `rx_ctl_valid`. Status bit 5 mirrors `tx_ctl_ready`.
- R5: Bit 7 (transmit underflow) sets at the clock edge that samples `tx_slot` high while `tx_level` is 0. Bit 9 (transmit overflow) sets at the edge that samples `tx_push` high while `tx_level` equals `TX_DEPTH`. The same strobes at other levels leave these bits at 0.
- R6: Bit 6 (receive overflow) sets at the edge that samples `rx_word` high while `rx_level` equals `RX_DEPTH`. Bit 8 (receive underflow) sets at the edge that samples `rx_pop` high while `rx_level` is 0.
- R7: Bit 10 (slot conflict) sets at an edge where `ctl_en` is 1 and `data_slot` equals `ctl_slot`. With `ctl_en` at 0, equal slot numbers have no effect.
- R8: Bit 11 (early sync) sets when, in slave mode, a rising edge on `sync_in` comes after fewer than `frame_bits` bit ticks since the previous sync. The first sync after reset never sets it. In master mode (`slave_mode` = 0) it never sets.
- R9: Bits 6 to 11 hold once set. A cycle with `clr_wr` = 1 clears each sticky bit whose `clr_data` bit is 1. Zeros in `clr_data` leave their bits alone. If a set event and a clear hit the same bit in the same cycle, the bit stays set. Clear writes do not change bits 0 to 5.
- R10: `irq` equals the OR of `status & irq_en`, one clock later.
- R11: While `rst_n` is low, bits 6 to 11 and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | TX_LW | Entries held in the transmit FIFO |
| rx_level | input | RX_LW | Entries held in the receive FIFO |
| tx_thresh | input | TX_LW | Free-space threshold for the transmit request |
| rx_thresh | input | RX_LW | Fill threshold for the receive request |
| tx_push | input | 1 | Host write strobe into the transmit FIFO |
| rx_pop | input | 1 | Host read strobe from the receive FIFO |
| tx_slot | input | 1 | Serial transmit slot needs a word |
| rx_word | input | 1 | Serial receiver delivers a word |
| sync_in | input | 1 | Frame sync |
| bit_tick | input | 1 | One serial bit period elapsed |
| slave_mode | input | 1 | 1 when the frame sync comes from outside |
| frame_bits | input | FBIT_W | Bits expected between frame syncs |
| data_slot | input | SLOT_W | Slot chosen for serial data |
| ctl_slot | input | SLOT_W | Slot chosen for control data |
| ctl_en | input | 1 | Control data slot in use |
| tx_ctl_ready | input | 1 | Transmit control register can take a write |
| rx_ctl_valid | input | 1 | Receive control register holds valid data |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 12 | Bits to clear |
| irq_en | input | 12 | Per-bit interrupt enables |
| status | output | 12 | Status word |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench targets the threshold edges. It checks free space exactly equal to the transmit threshold, and a fill level exactly at the receive threshold. A wrong comparison (greater-or-equal against greater) would flip the request at those points.

It strobes the fault conditions at levels just inside the legal range, so a flag that ignores the level check shows up as a false error. It lands a set event and a clear on the same bit in the same cycle, and expects the set to win. A frame sync after exactly `frame_bits` ticks must pass, and one after fewer must flag. A first sync or a master-mode sync that reports an error exposes a monitor with no arming rule or no mode gate.

// File: rtl/sfis_pkg.sv
package sfis_pkg;
   localparam int NSTAT  = 12;
   localparam int NLIVE  = 6;
   localparam int NERR   = 6;
   // live bits
   localparam int B_TXREQ  = 0;
   localparam int B_RXREQ  = 1;
   localparam int B_TXEMP  = 2;
   localparam int B_RXFULL = 3;
   localparam int B_RXCTL  = 4;
   localparam int B_TXCTL  = 5;
   // sticky bits
   localparam int B_RXOVR  = 6;
   localparam int B_TXUND  = 7;
   localparam int B_RXUND  = 8;
   localparam int B_TXOVR  = 9;
   localparam int B_SLOT   = 10;
   localparam int B_SYNC   = 11;
endpackage

// File: rtl/sfis_level.sv
module sfis_level #(
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16,
   parameter int TX_LW    = $clog2(TX_DEPTH + 1),
   parameter int RX_LW    = $clog2(RX_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TX_LW-1:0] tx_level,
   input  logic [RX_LW-1:0] rx_level,
   input  logic [TX_LW-1:0] tx_thresh,
   input  logic [RX_LW-1:0] rx_thresh,
   input  logic             tx_ctl_ready,
   input  logic             rx_ctl_valid,
   output logic [sfis_pkg::NLIVE-1:0] live
);
   import sfis_pkg::*;

   localparam logic [TX_LW-1:0] TX_FULL_V = TX_LW'(TX_DEPTH);
   localparam logic [RX_LW-1:0] RX_FULL_V = RX_LW'(RX_DEPTH);

   logic [TX_LW-1:0] tx_free;

   assign tx_free = TX_FULL_V - tx_level;

   always_comb begin
      live           = '0;
      live[B_TXREQ]  = tx_free > tx_thresh;
      live[B_RXREQ]  = rx_level >= rx_thresh;
      live[B_TXEMP]  = tx_level == '0;
      live[B_RXFULL] = rx_level == RX_FULL_V;
      live[B_RXCTL]  = rx_ctl_valid;
      live[B_TXCTL]  = tx_ctl_ready;
   end

   // levels reported by the FIFOs never exceed their depth (R3)
   p_tx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= TX_FULL_V);
   p_rx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= RX_FULL_V);
   // an empty transmit FIFO requests data whenever the threshold is below depth (R1)
   p_empty_requests_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == '0 && tx_thresh < TX_FULL_V) |-> live[B_TXREQ]);
endmodule

// File: rtl/sfis_fsmon.sv
module sfis_fsmon #(
   parameter int FBIT_W    = 8,
   parameter bit SYNC_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_in,
   input  logic              bit_tick,
   input  logic              slave_mode,
   input  logic [FBIT_W-1:0] frame_bits,
   output logic              early_evt
);
   localparam logic [FBIT_W-1:0] CNT_MAX = '1;

   logic              sync_evt;
   logic              armed;
   logic [FBIT_W-1:0] bit_cnt;

   // variant: edge-detect a level sync, or take a one-cycle pulse as is
   generate
      if (SYNC_RISE) begin : g_edge
         logic sync_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_d <= 1'b0;
            else        sync_d <= sync_in;
         end
         assign sync_evt = sync_in & ~sync_d;
      end else begin : g_pulse
         assign sync_evt = sync_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         bit_cnt <= '0;
      end else if (sync_evt) begin
         armed   <= 1'b1;
         bit_cnt <= '0;
      end else if (bit_tick && bit_cnt != CNT_MAX) begin
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign early_evt = slave_mode & sync_evt & armed & (bit_cnt < frame_bits);

   // master mode never reports an early sync (R8)
   p_master_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_mode |-> !early_evt);
   // the very first sync after reset is never early (R8)
   p_first_sync_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !early_evt);
endmodule

// File: rtl/sfis_sticky.sv
module sfis_sticky #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_bits,
   output logic [N-1:0] flags
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      flags[i] <= 1'b0;
            else if (set_evt[i])             flags[i] <= 1'b1;
            else if (clr_wr && clr_bits[i])  flags[i] <= 1'b0;
         end

         p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(clr_wr && clr_bits[i])) |=> flags[i]);
         p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flags[i]);
         p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_bits[i] && !set_evt[i]) |=> !flags[i]);
      end
   endgenerate
endmodule

// File: rtl/sfifo_irq_status.sv
module sfifo_irq_status #(
   parameter int TX_DEPTH  = 16,
   parameter int RX_DEPTH  = 16,
   parameter int FBIT_W    = 8,
   parameter int SLOT_W    = 4,
   parameter bit SYNC_RISE = 1'b1,
   parameter int TX_LW     = $clog2(TX_DEPTH + 1),
   parameter int RX_LW     = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TX_LW-1:0]  tx_level,
   input  logic [RX_LW-1:0]  rx_level,
   input  logic [TX_LW-1:0]  tx_thresh,
   input  logic [RX_LW-1:0]  rx_thresh,
   input  logic              tx_push,
   input  logic              rx_pop,
   input  logic              tx_slot,
   input  logic              rx_word,
   input  logic              sync_in,
   input  logic              bit_tick,
   input  logic              slave_mode,
   input  logic [FBIT_W-1:0] frame_bits,
   input  logic [SLOT_W-1:0] data_slot,
   input  logic [SLOT_W-1:0] ctl_slot,
   input  logic              ctl_en,
   input  logic              tx_ctl_ready,
   input  logic              rx_ctl_valid,
   input  logic              clr_wr,
   input  logic [11:0]       clr_data,
   input  logic [11:0]       irq_en,
   output logic [11:0]       status,
   output logic              irq
);
   import sfis_pkg::*;

   localparam int EOFF = NLIVE;

   generate
      if (TX_DEPTH < 2 || RX_DEPTH < 2) begin : g_bad_depth
         $error("FIFO depths must be at least 2");
      end
      if (FBIT_W < 2 || SLOT_W < 1) begin : g_bad_width
         $error("frame counter or slot field too narrow");
      end
   endgenerate

   logic [NLIVE-1:0] live;
   logic [NERR-1:0]  err_evt;
   logic [NERR-1:0]  err_q;
   logic             early_evt;

   sfis_level #(
      .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TX_LW(TX_LW), .RX_LW(RX_LW)
   ) u_level (
      .clk(clk), .rst_n(rst_n),
      .tx_level(tx_level), .rx_level(rx_level),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
      .tx_ctl_ready(tx_ctl_ready), .rx_ctl_valid(rx_ctl_valid),
      .live(live)
   );

   sfis_fsmon #(.FBIT_W(FBIT_W), .SYNC_RISE(SYNC_RISE)) u_fsmon (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .bit_tick(bit_tick),
      .slave_mode(slave_mode), .frame_bits(frame_bits), .early_evt(early_evt)
   );

   always_comb begin
      err_evt                = '0;
      err_evt[B_RXOVR-EOFF]  = rx_word & (rx_level == RX_LW'(RX_DEPTH));
      err_evt[B_TXUND-EOFF]  = tx_slot & (tx_level == '0);
      err_evt[B_RXUND-EOFF]  = rx_pop  & (rx_level == '0);
      err_evt[B_TXOVR-EOFF]  = tx_push & (tx_level == TX_LW'(TX_DEPTH));
      err_evt[B_SLOT-EOFF]   = ctl_en  & (data_slot == ctl_slot);
      err_evt[B_SYNC-EOFF]   = early_evt;
   end

   sfis_sticky #(.N(NERR)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_evt(err_evt),
      .clr_wr(clr_wr), .clr_bits(clr_data[NSTAT-1:EOFF]), .flags(err_q)
   );

   assign status = {err_q, live};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(status & irq_en);
   end

   // interrupt only after some enable was set the cycle before (R10)
   p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(irq_en != '0));
   p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |=> !irq);
   // a clear write never disturbs the live half (R9)
   p_live_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && $stable(live)) |-> (status[NLIVE-1:0] == live));
endmodule

// File: tb/sim_sfifo_irq_status.sv
`timescale 1ns/1ps
module sim_sfifo_irq_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  tx_level = '0, rx_level = '0, tx_thresh = 5'd4, rx_thresh = 5'd4;
   logic        tx_push = 0, rx_pop = 0, tx_slot = 0, rx_word = 0;
   logic        sync_in = 0, bit_tick = 0, slave_mode = 0;
   logic [7:0]  frame_bits = 8'd4;
   logic [3:0]  data_slot = 4'd1, ctl_slot = 4'd2;
   logic        ctl_en = 0, tx_ctl_ready = 0, rx_ctl_valid = 0;
   logic        clr_wr = 0;
   logic [11:0] clr_data = '0, irq_en = '0;
   logic [11:0] status;
   logic        irq;

   int checks = 0;
   int errs   = 0;

   always #2 clk = ~clk;

   sfifo_irq_status u0 (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .tx_push(tx_push),
      .rx_pop(rx_pop), .tx_slot(tx_slot), .rx_word(rx_word), .sync_in(sync_in),
      .bit_tick(bit_tick), .slave_mode(slave_mode), .frame_bits(frame_bits),
      .data_slot(data_slot), .ctl_slot(ctl_slot), .ctl_en(ctl_en),
      .tx_ctl_ready(tx_ctl_ready), .rx_ctl_valid(rx_ctl_valid),
      .clr_wr(clr_wr), .clr_data(clr_data), .irq_en(irq_en),
      .status(status), .irq(irq)
   );

   // {tx_level, rx_level, tx_thresh, rx_thresh, tx_ctl_ready, rx_ctl_valid, expected bits[5:0]}
   localparam int NV = 6;
   localparam logic [27:0] VEC [NV] = '{
      {5'd0,  5'd0,  5'd4,  5'd4,  1'b0, 1'b0, 6'b000101},
      {5'd12, 5'd4,  5'd4,  5'd4,  1'b1, 1'b0, 6'b100010},
      {5'd11, 5'd3,  5'd4,  5'd4,  1'b0, 1'b1, 6'b010001},
      {5'd16, 5'd16, 5'd0,  5'd16, 1'b1, 1'b1, 6'b111010},
      {5'd15, 5'd15, 5'd0,  5'd16, 1'b0, 1'b0, 6'b000001},
      {5'd0,  5'd16, 5'd16, 5'd0,  1'b0, 1'b0, 6'b001110}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic clear(input logic [11:0] m);
      clr_wr = 1'b1; clr_data = m;
      step();
      clr_wr = 1'b0; clr_data = '0;
   endtask

   initial begin
      #400000;
      errs++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      // R11: reset state, live bits already reflect tx_level 0 with thresholds 4
      step(); step();
      chk("R11 status in reset", {20'd0, status}, 32'h005);
      chk("R11 irq in reset", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      step();

      // table walk over level flags: R1 R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         {tx_level, rx_level, tx_thresh, rx_thresh, tx_ctl_ready, rx_ctl_valid} = VEC[i][27:6];
         #1;
         chk($sformatf("R1 R2 R3 R4 vector %0d", i), {26'd0, status[5:0]}, {26'd0, VEC[i][5:0]});
      end
      chk("R5 R6 no errors from levels", {26'd0, status[11:6]}, 32'd0);

      // R5: strobes at legal levels do nothing
      tx_level = 5'd1; tx_slot = 1; step(); tx_slot = 0;
      tx_level = 5'd15; tx_push = 1; step(); tx_push = 0;
      chk("R5 no false tx error", {31'd0, status[7] | status[9]}, 32'd0);
      tx_level = 5'd0; tx_slot = 1; step(); tx_slot = 0;
      chk("R5 underflow set", {31'd0, status[7]}, 32'd1);
      tx_level = 5'd16; tx_push = 1; step(); tx_push = 0;
      chk("R5 overflow set", {31'd0, status[9]}, 32'd1);

      // R6
      rx_level = 5'd15; rx_word = 1; step(); rx_word = 0;
      rx_level = 5'd1; rx_pop = 1; step(); rx_pop = 0;
      chk("R6 no false rx error", {31'd0, status[6] | status[8]}, 32'd0);
      rx_level = 5'd16; rx_word = 1; step(); rx_word = 0;
      rx_level = 5'd0; rx_pop = 1; step(); rx_pop = 0;
      chk("R6 rx overflow and underflow", {30'd0, status[8], status[6]}, 32'd3);

      // R9: zero mask keeps flags, ones clear them, live half untouched
      tx_level = 5'd8; rx_level = 5'd8; tx_thresh = 5'd4; rx_thresh = 5'd4;
      clear(12'h03F);
      chk("R9 zero bits ignored", {26'd0, status[11:6]}, 32'h0F);
      chk("R9 live bits unaffected", {26'd0, status[5:0]}, 32'h03);
      clear(12'h0C0);
      chk("R9 selective clear", {26'd0, status[11:6]}, 32'h0C);
      tx_level = 5'd0; tx_slot = 1; clr_wr = 1; clr_data = 12'h080;
      step();
      tx_slot = 0; clr_wr = 0; clr_data = '0;
      chk("R9 set wins over clear", {31'd0, status[7]}, 32'd1);

      // R10: interrupt one cycle after enable
      irq_en = 12'h080; #1;
      chk("R10 irq not yet", {31'd0, irq}, 32'd0);
      step();
      chk("R10 irq raised", {31'd0, irq}, 32'd1);
      irq_en = 12'h000; step();
      chk("R10 irq dropped", {31'd0, irq}, 32'd0);
      irq_en = 12'h004; step();
      chk("R10 irq from live bit", {31'd0, irq}, 32'd1);
      irq_en = 12'h000;
      clear(12'hFFF);
      chk("R9 all sticky cleared", {26'd0, status[11:6]}, 32'd0);

      // R7
      data_slot = 4'd3; ctl_slot = 4'd3; ctl_en = 0; step();
      chk("R7 disabled control slot ignored", {31'd0, status[10]}, 32'd0);
      ctl_en = 1; step(); ctl_en = 0;
      chk("R7 slot conflict", {31'd0, status[10]}, 32'd1);
      ctl_slot = 4'd5; clear(12'h400);
      chk("R7 slot conflict cleared", {31'd0, status[10]}, 32'd0);

      // R8
      slave_mode = 1; frame_bits = 8'd4;
      sync_in = 1; step(); sync_in = 0;
      chk("R8 first sync not early", {31'd0, status[11]}, 32'd0);
      bit_tick = 1; repeat (4) step(); bit_tick = 0;
      sync_in = 1; step(); sync_in = 0;
      chk("R8 sync after full frame", {31'd0, status[11]}, 32'd0);
      bit_tick = 1; repeat (2) step(); bit_tick = 0;
      sync_in = 1; step(); sync_in = 0;
      chk("R8 early sync flagged", {31'd0, status[11]}, 32'd1);
      clear(12'h800);
      slave_mode = 0;
      sync_in = 1; step(); sync_in = 0;
      chk("R8 master mode ignores early sync", {31'd0, status[11]}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule